// File: doc/BRIEF.md
# Memory Access Region and Permission Checker

This block sits beside the address translation path of a 32-bit processor and decides, for every memory access, whether it goes straight through untranslated, goes through a translation entry supplied by an external lookup, or stops with a fault. The external lookup returns a hit flag, the virtual and physical page numbers of the matching entry, and its read, write and execute grants. The block does not hold or replace translation entries.

Fixed regions of the address space set the policy. When translation is switched off, every address maps to itself. A supervisor access to the top quarter of the space bypasses the lookup. A user access to the top half faults at once. Every other access is checked against the lookup result.

A fault that is not a probe leaves behind what refill software needs. The full faulting address is stored. For lookup faults, a data-side flag and the faulting virtual page number are also stored. A probe request gets the same answer with no side effects. Each request is answered one clock after it is presented.

Top module: `mmu_access_check`

## Requirements
- R1: With `mmuOn` low, every request is granted and `paddr` equals `vaddr`, whatever the mode and address.
- R2: With `mmuOn` high, a supervisor request (`userMode` low) at or above 0xC000_0000 is granted with `paddr` equal to `vaddr`, whatever the lookup inputs.
- R3: With `mmuOn` high, a user request at or above 0x8000_0000 faults with cause 1 for a fetch and cause 2 otherwise. It stores the address in `badAddr` and leaves `miscD` and `pteVpn` unchanged.
- R4: Access types are encoded as 0 load, 1 store and 2 fetch; code 3 is treated as a load. On a lookup hit, a load needs read, a store needs write and a fetch needs execute to be granted.
- R5: A translated grant gives `paddr` = ((`tlbPpn` + `vaddr[31:12]` - `tlbVpn`) << 12) | `vaddr[11:0]`. When the request is not granted, `paddr` reads 0.
- R6: A hit without the needed permission faults with cause 3 (load), 4 (store) or 5 (fetch). A lookup miss faults with cause 6 for a fetch and cause 7 otherwise.
- R7: On causes 3 to 7, the block stores the full address in `badAddr`, `vaddr[31:12]` in `pteVpn`, and in `miscD` a 1 exactly when the access is not a fetch.
- R8: A request with `probe` high never raises `faultPulse`, reports cause 0 and changes none of `badAddr`, `miscD` or `pteVpn`. It is granted exactly when the same request without `probe` would be granted.
- R9: Results appear the cycle after `reqValid`. `rspValid`, `grant` and `faultPulse` are single-cycle pulses. In a cycle with no request, these are 0 and the cause is 0, while the stored fault registers hold their values.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present this cycle |
| vaddr | input | 32 | Virtual address of the access |
| accType | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| userMode | input | 1 | 1 for user privilege, 0 for supervisor |
| probe | input | 1 | Query only, no fault and no register update |
| mmuOn | input | 1 | Translation enabled |
| tlbHit | input | 1 | External lookup found an entry |
| tlbPpn | input | 20 | Physical page number of the entry |
| tlbVpn | input | 20 | Virtual page number of the entry |
| tlbRead | input | 1 | Entry grants read |
| tlbWrite | input | 1 | Entry grants write |
| tlbExec | input | 1 | Entry grants execute |
| rspValid | output | 1 | Result valid pulse |
| grant | output | 1 | Access allowed |
| paddr | output | 32 | Physical address when granted, else 0 |
| faultPulse | output | 1 | One-cycle fault indication |
| faultCause | output | 4 | Fault cause code, 0 when no fault |
| badAddr | output | 32 | Last faulting address |
| miscD | output | 1 | Last lookup fault was data-side |
| pteVpn | output | 20 | Virtual page number of the last lookup fault |

## Verification
The assertions assume that the lookup inputs are stable and meaningful in the same cycle as `reqValid`, and that reset is asserted before the first request. They also assume the region inputs (`mmuOn`, `userMode`, `probe`) are known whenever a request is present. The bench drives every request field on the falling edge together with `reqValid` and holds them through the rising edge. It never leaves a request field unknown. Vectors that exercise the bypass regions still drive arbitrary lookup values, which shows that the lookup is ignored there.

// File: rtl/mmu_chk_pkg.sv
package mmu_chk_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  typedef enum logic [3:0] {
    CAUSE_NONE   = 4'd0,
    CAUSE_SUPA_I = 4'd1,
    CAUSE_SUPA_D = 4'd2,
    CAUSE_PERM_R = 4'd3,
    CAUSE_PERM_W = 4'd4,
    CAUSE_PERM_X = 4'd5,
    CAUSE_MISS_I = 4'd6,
    CAUSE_MISS_D = 4'd7
  } cause_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   accept;    // grant this request
    logic   bypass;    // identity mapping
    logic   fault;     // raise fault pulse
    logic   recBad;    // store bad address
    logic   recTlb;    // store data-side flag and page number
    logic   dataSide;  // access is not a fetch
    cause_e cause;
  } strobe_t;

endpackage

// File: rtl/mmu_chk_ctrl.sv
module mmu_chk_ctrl
  import mmu_chk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] KERNEL_BASE = 32'hC000_0000,
  parameter logic [ADDR_W-1:0] USER_LIMIT  = 32'h8000_0000
) (
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        accType,
  input  logic              userMode,
  input  logic              probe,
  input  logic              mmuOn,
  input  logic              tlbHit,
  input  logic              tlbRead,
  input  logic              tlbWrite,
  input  logic              tlbExec,
  output strobe_t           strb
);

  logic isFetch;
  logic permOk;
  cause_e permCause;

  assign isFetch = (accType == ACC_FETCH);

  always_comb begin
    unique case (accType)
      ACC_STORE: begin permOk = tlbWrite; permCause = CAUSE_PERM_W; end
      ACC_FETCH: begin permOk = tlbExec;  permCause = CAUSE_PERM_X; end
      default:   begin permOk = tlbRead;  permCause = CAUSE_PERM_R; end
    endcase
  end

  always_comb begin
    strb = '0;
    strb.dataSide = !isFetch;
    if (reqValid) begin
      if (!mmuOn || (!userMode && vaddr >= KERNEL_BASE)) begin
        strb.accept = 1'b1;
        strb.bypass = 1'b1;
      end else if (userMode && vaddr >= USER_LIMIT) begin
        strb.fault  = 1'b1;
        strb.recBad = 1'b1;
        strb.cause  = isFetch ? CAUSE_SUPA_I : CAUSE_SUPA_D;
      end else if (tlbHit && permOk) begin
        strb.accept = 1'b1;
      end else begin
        strb.fault  = 1'b1;
        strb.recBad = 1'b1;
        strb.recTlb = 1'b1;
        if (tlbHit) strb.cause = permCause;
        else        strb.cause = isFetch ? CAUSE_MISS_I : CAUSE_MISS_D;
      end
      if (probe) begin
        strb.fault  = 1'b0;
        strb.recBad = 1'b0;
        strb.recTlb = 1'b0;
        strb.cause  = CAUSE_NONE;
      end
    end
  end

endmodule

// File: rtl/mmu_chk_dp.sv
module mmu_chk_dp
  import mmu_chk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  localparam int VPN_W    = ADDR_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [VPN_W-1:0]  tlbPpn,
  input  logic [VPN_W-1:0]  tlbVpn,
  output logic              rspValid,
  output logic              grant,
  output logic [ADDR_W-1:0] paddr,
  output logic              faultPulse,
  output logic [3:0]        faultCause,
  output logic [ADDR_W-1:0] badAddr,
  output logic              miscD,
  output logic [VPN_W-1:0]  pteVpn
);

  logic [VPN_W-1:0]  pageOfAddr;
  logic [VPN_W-1:0]  physPage;
  logic [ADDR_W-1:0] physNext;

  assign pageOfAddr = vaddr[ADDR_W-1:PAGE_BITS];
  assign physPage   = tlbPpn + (pageOfAddr - tlbVpn);
  assign physNext   = strb.bypass ? vaddr : {physPage, vaddr[PAGE_BITS-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rspValid   <= 1'b0;
      grant      <= 1'b0;
      paddr      <= '0;
      faultPulse <= 1'b0;
      faultCause <= '0;
    end else begin
      rspValid   <= reqValid;
      grant      <= strb.accept;
      paddr      <= strb.accept ? physNext : '0;
      faultPulse <= strb.fault;
      faultCause <= strb.cause;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      badAddr <= '0;
      miscD   <= 1'b0;
      pteVpn  <= '0;
    end else begin
      if (strb.recBad) badAddr <= vaddr;
      if (strb.recTlb) begin
        miscD  <= strb.dataSide;
        pteVpn <= pageOfAddr;
      end
    end
  end

  // R9: a fault and a grant never coincide
  a_r9_grant_xor_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !(grant && faultPulse));

  // R7: the stored bad address is the address of the request that faulted
  a_r7_bad_addr_match: assert property (@(posedge clk) disable iff (!rst_n)
    faultPulse |-> badAddr == $past(vaddr));

  // R9: no request means no result in the next cycle
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rspValid && !grant && !faultPulse && faultCause == 4'd0);

endmodule

// File: rtl/mmu_access_check.sv
module mmu_access_check
  import mmu_chk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter logic [ADDR_W-1:0] KERNEL_BASE = 32'hC000_0000,
  parameter logic [ADDR_W-1:0] USER_LIMIT  = 32'h8000_0000,
  localparam int VPN_W    = ADDR_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] vaddr,
  input  logic [1:0]        accType,
  input  logic              userMode,
  input  logic              probe,
  input  logic              mmuOn,
  input  logic              tlbHit,
  input  logic [VPN_W-1:0]  tlbPpn,
  input  logic [VPN_W-1:0]  tlbVpn,
  input  logic              tlbRead,
  input  logic              tlbWrite,
  input  logic              tlbExec,
  output logic              rspValid,
  output logic              grant,
  output logic [ADDR_W-1:0] paddr,
  output logic              faultPulse,
  output logic [3:0]        faultCause,
  output logic [ADDR_W-1:0] badAddr,
  output logic              miscD,
  output logic [VPN_W-1:0]  pteVpn
);

  strobe_t strb;

  mmu_chk_ctrl #(
    .ADDR_W(ADDR_W), .KERNEL_BASE(KERNEL_BASE), .USER_LIMIT(USER_LIMIT)
  ) u_ctrl (
    .reqValid(reqValid), .vaddr(vaddr), .accType(accType),
    .userMode(userMode), .probe(probe), .mmuOn(mmuOn),
    .tlbHit(tlbHit), .tlbRead(tlbRead), .tlbWrite(tlbWrite),
    .tlbExec(tlbExec), .strb(strb)
  );

  mmu_chk_dp #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_dp (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .strb(strb),
    .vaddr(vaddr), .tlbPpn(tlbPpn), .tlbVpn(tlbVpn),
    .rspValid(rspValid), .grant(grant), .paddr(paddr),
    .faultPulse(faultPulse), .faultCause(faultCause),
    .badAddr(badAddr), .miscD(miscD), .pteVpn(pteVpn)
  );

  // R1: translation off maps every address to itself
  a_r1_identity_off: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !mmuOn) |=> grant && paddr == $past(vaddr));

  // R2: supervisor kernel window bypasses the lookup
  a_r2_kernel_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && mmuOn && !userMode && vaddr >= KERNEL_BASE)
      |=> grant && paddr == $past(vaddr));

  // R3: user access to the upper half is locked out
  a_r3_user_lockout: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && mmuOn && userMode && !probe && vaddr >= USER_LIMIT)
      |=> faultPulse && !grant && $stable(pteVpn) && $stable(miscD));

  // R8: probes leave no trace
  a_r8_probe_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && probe) |=> !faultPulse && $stable(badAddr)
      && $stable(pteVpn) && $stable(miscD));

endmodule

// File: tb/tb_mmu_access_check.sv
module tb_mmu_access_check;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] vaddr = '0;
  logic [1:0]  accType = '0;
  logic        userMode = 1'b0, probe = 1'b0, mmuOn = 1'b0, tlbHit = 1'b0;
  logic [19:0] tlbPpn = '0, tlbVpn = '0;
  logic        tlbRead = 1'b0, tlbWrite = 1'b0, tlbExec = 1'b0;
  logic        rspValid, grant, faultPulse, miscD;
  logic [31:0] paddr, badAddr;
  logic [3:0]  faultCause;
  logic [19:0] pteVpn;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mmu_access_check dut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .vaddr(vaddr),
    .accType(accType), .userMode(userMode), .probe(probe), .mmuOn(mmuOn),
    .tlbHit(tlbHit), .tlbPpn(tlbPpn), .tlbVpn(tlbVpn), .tlbRead(tlbRead),
    .tlbWrite(tlbWrite), .tlbExec(tlbExec), .rspValid(rspValid),
    .grant(grant), .paddr(paddr), .faultPulse(faultPulse),
    .faultCause(faultCause), .badAddr(badAddr), .miscD(miscD), .pteVpn(pteVpn)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  acc;
    logic        usr, prb, mmu, hit;
    logic [19:0] ppn, vpn;
    logic        r, w, x;
    logic        eGrant;
    logic [31:0] ePaddr;
    logic [3:0]  eCause;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R1: translation off, user high address still identity
    '{32'h9234_5678, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 20'h0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h9234_5678, 4'd0, 8'd1},
    // R2: supervisor kernel window, lookup reports miss and is ignored
    '{32'hC000_1004, 2'd2, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hC000_1004, 4'd0, 8'd2},
    // R3: user data access to upper half
    '{32'h8000_0010, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 20'h1, 20'h80000, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0, 4'd2, 8'd3},
    // R3: user fetch to upper half
    '{32'hFFFF_F000, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 20'h0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 4'd1, 8'd3},
    // R4 R5: load hit with read
    '{32'h0001_2345, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 20'h00ABC, 20'h00012, 1'b1, 1'b0, 1'b0, 1'b1, 32'h00AB_C345, 4'd0, 8'd4},
    // R4 R5: user store hit with write only
    '{32'h0004_5FFC, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1, 20'h12345, 20'h00045, 1'b0, 1'b1, 1'b0, 1'b1, 32'h1234_5FFC, 4'd0, 8'd4},
    // R5: entry page differs from access page, offset added
    '{32'h0004_2010, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 20'h00100, 20'h00040, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0010_2010, 4'd0, 8'd5},
    // R6 R7: load without read
    '{32'h1000_0ABC, 2'd0, 1'b1, 1'b0, 1'b1, 1'b1, 20'h5, 20'h10000, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 4'd3, 8'd6},
    // R6 R7: store without write
    '{32'h2000_0004, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 20'h5, 20'h20000, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0, 4'd4, 8'd6},
    // R6 R7: fetch without execute
    '{32'h3000_0008, 2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 20'h5, 20'h30000, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 4'd5, 8'd6},
    // R6 R7: fetch miss
    '{32'h0ABC_D000, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0, 20'h0, 20'h0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0, 4'd6, 8'd7},
    // R6 R7: supervisor load miss just below kernel window
    '{32'hBFFF_FFFC, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 20'h0, 20'h0, 1'b1, 1'b1, 1'b1, 1'b0, 32'h0, 4'd7, 8'd7},
    // R8: probe of a store miss
    '{32'h5555_5000, 2'd1, 1'b0, 1'b1, 1'b1, 1'b0, 20'h0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 4'd0, 8'd8},
    // R8: probe of a user high access
    '{32'hA000_0000, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 20'h0, 20'h0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 4'd0, 8'd8},
    // R8: probe of a permitted hit still grants
    '{32'h0000_7123, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 20'h00042, 20'h00007, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0004_2123, 4'd0, 8'd8},
    // R4: reserved type 3 behaves as a load
    '{32'h0000_3FF0, 2'd3, 1'b0, 1'b0, 1'b1, 1'b1, 20'h00009, 20'h00003, 1'b1, 1'b0, 1'b0, 1'b1, 32'h0000_9FF0, 4'd0, 8'd4}
  };

  task automatic check(input string name, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", name, act, exp);
    end
  endtask

  logic [31:0] expBad = '0;
  logic        expD = 1'b0;
  logic [19:0] expVpn = '0;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check("R10 rspValid", {31'b0, rspValid}, 32'd0);
    check("R10 grant", {31'b0, grant}, 32'd0);
    check("R10 paddr", paddr, 32'd0);
    check("R10 fault", {27'b0, faultPulse, faultCause}, 32'd0);
    check("R10 regs", badAddr | {12'b0, pteVpn} | {31'b0, miscD}, 32'd0);
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      reqValid = 1'b1;
      vaddr = VECS[i].va; accType = VECS[i].acc; userMode = VECS[i].usr;
      probe = VECS[i].prb; mmuOn = VECS[i].mmu; tlbHit = VECS[i].hit;
      tlbPpn = VECS[i].ppn; tlbVpn = VECS[i].vpn;
      tlbRead = VECS[i].r; tlbWrite = VECS[i].w; tlbExec = VECS[i].x;
      if (VECS[i].eCause != 4'd0) begin
        expBad = VECS[i].va;
        if (VECS[i].eCause >= 4'd3) begin
          expD   = (VECS[i].acc != 2'd2);
          expVpn = VECS[i].va[31:12];
        end
      end
      @(posedge clk);
      #1;
      $display("vector %0d for R%0d", i, VECS[i].req);
      check($sformatf("R%0d v%0d grant", VECS[i].req, i), {31'b0, grant}, {31'b0, VECS[i].eGrant});
      check($sformatf("R%0d v%0d paddr", VECS[i].req, i), paddr, VECS[i].ePaddr);
      check($sformatf("R%0d v%0d cause", VECS[i].req, i), {28'b0, faultCause}, {28'b0, VECS[i].eCause});
      check($sformatf("R%0d v%0d pulse", VECS[i].req, i), {31'b0, faultPulse}, {31'b0, (VECS[i].eCause != 4'd0)});
      check($sformatf("R9 v%0d rspValid", i), {31'b0, rspValid}, 32'd1);
      check($sformatf("R7 v%0d badAddr", i), badAddr, expBad);
      check($sformatf("R7 v%0d miscD", i), {31'b0, miscD}, {31'b0, expD});
      check($sformatf("R7 v%0d pteVpn", i), {12'b0, pteVpn}, {12'b0, expVpn});
    end

    // R9: a fault followed by an idle cycle, the pulse drops and the registers hold
    @(negedge clk);
    vaddr = 32'h0777_7004; accType = 2'd1; userMode = 1'b0; probe = 1'b0;
    mmuOn = 1'b1; tlbHit = 1'b0;
    @(posedge clk); #1;
    check("R6 store miss cause", {28'b0, faultCause}, 32'd7);
    check("R7 store miss vpn", {12'b0, pteVpn}, 32'h0_7777);
    @(negedge clk) reqValid = 1'b0;
    @(posedge clk); #1;
    check("R9 idle rspValid", {31'b0, rspValid}, 32'd0);
    check("R9 idle pulse", {31'b0, faultPulse}, 32'd0);
    check("R9 idle cause", {28'b0, faultCause}, 32'd0);
    check("R9 idle grant/paddr", {31'b0, grant} | paddr, 32'd0);
    check("R9 idle badAddr hold", badAddr, 32'h0777_7004);
    check("R9 idle miscD hold", {31'b0, miscD}, 32'd1);

    // R10: asynchronous reset clears everything again
    @(negedge clk) rst_n = 1'b0;
    #2;
    check("R10 rereset regs", badAddr | {12'b0, pteVpn} | {31'b0, miscD}, 32'd0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule